// File: doc/BRIEF.md
# Atomic Exchange Unit

This block carries out an atomic swap between a register value and a word of memory, the operation a core uses to take a spin lock. The core supplies an address and a register value. The unit first asks for exclusive, writable ownership of the cache line that holds the address. Once ownership is granted, it reads the word and then writes the register value back in its place. It returns the old word through a one-cycle completion pulse. By convention the lock word holds 1 when the lock is taken and 0 when it is free. A returned 0 therefore means the caller now holds the lock, and a returned 1 means it must try again.

To make the read and the write look indivisible to every other agent, the unit sits in the coherence request path. It withholds any request aimed at the line being swapped, whether that request comes from the local cache, a peer cache or the directory. One such request is parked in a single-entry buffer and released in the completion cycle, after the write. Requests for other lines pass straight through. Cache and directory internals are not modelled: an ownership request/grant pair and a word-wide memory port stand in for them.

Top module: `atomic_swap_unit`

## Requirements
- R1: While reset is held and after it, `busy`, `own_req`, `mem_rd`, `mem_wr` and `done` are 0. An operation is taken when `op_valid` is high and `busy` is low, and `busy` stays high from the next cycle through the completion cycle.
- R2: After taking an operation, the unit raises `own_req` with `own_addr` equal to the operation address. It issues no memory access until it sees `own_grant` high at a clock edge. The read (`mem_rd` high) occurs in the cycle that follows that edge.
- R3: The read lasts exactly one cycle. In the next cycle `mem_wr` is high, with `mem_addr` equal to the operation address and `mem_wdata` equal to the register value, so that the memory word afterwards holds the register value.
- R4: `done` is high for exactly one cycle, the cycle after the write. In that cycle `old_value` equals the word returned by the read.
- R5: `got_lock` is high in the completion cycle when the old word is 0. It is low when the old word is nonzero, which means retry.
- R6: A coherence request whose line (address bits above the low `LINE_OFS_W` offset bits) matches the operation's line is not forwarded between taking the operation and the end of the write. The first such request is accepted (`snp_in_ready` high) into the holding buffer.
- R7: A held request appears on `snp_out_valid`/`snp_out_addr` in the completion cycle, after the write.
- R8: While the buffer is occupied, another request for the same line sees `snp_in_ready` low and is not forwarded.
- R9: During an operation, a request for a different line is forwarded in the same cycle with its address unchanged.
- R10: With no operation in progress, requests are forwarded in the same cycle with `snp_in_ready` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Start an exchange |
| op_addr | input | AW | Byte address of the lock word |
| op_wdata | input | DW | Register value to store |
| busy | output | 1 | Exchange in progress |
| own_req | output | 1 | Request exclusive ownership of the line |
| own_addr | output | AW | Address for the ownership request |
| own_grant | input | 1 | Line held in modified state with write permission |
| mem_rd | output | 1 | Word read strobe |
| mem_wr | output | 1 | Word write strobe |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid in the read cycle |
| done | output | 1 | Completion pulse |
| old_value | output | DW | Previous memory word, valid with done |
| got_lock | output | 1 | Old word was zero (lock taken) |
| snp_in_valid | input | 1 | Incoming coherence request |
| snp_in_addr | input | AW | Address of the incoming request |
| snp_in_ready | output | 1 | Incoming request accepted |
| snp_out_valid | output | 1 | Request forwarded to the responder |
| snp_out_addr | output | AW | Address of the forwarded request |

## Verification
The bench holds the grant back for several cycles and watches for any memory access before it arrives. A unit that read early would return a word that another agent could still change. It sends a same-line request inside the window and checks that nothing goes out until the completion cycle. Leaking the request early would break atomicity, and dropping it would hang the requester. A second same-line request must meet back-pressure, because overwriting the single buffer would lose the first. It also checks that requests for other lines are not stalled. Back-to-back swaps on one word cover the acquire and retry outcomes, so an inverted lock flag or a stale old value shows up.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_OWN,
    ST_READ,
    ST_WRITE,
    ST_RESPOND
  } xchg_state_e;
endpackage

// File: rtl/xchg_seq.sv
module xchg_seq
  import xchg_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_wdata,
  output logic          busy,
  output logic          own_req,
  output logic [AW-1:0] own_addr,
  input  logic          own_grant,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic [DW-1:0] old_value,
  output logic          got_lock,
  output logic          hold,
  output logic          respond,
  output logic [AW-1:0] cur_addr
);
  xchg_state_e st_q, st_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] reg_q, old_q;

  function automatic logic word_is_free(input logic [DW-1:0] w);
    return (w == '0);
  endfunction

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (op_valid) st_d = ST_REQ_OWN;
      ST_REQ_OWN: if (own_grant) st_d = ST_READ;
      ST_READ:    st_d = ST_WRITE;
      ST_WRITE:   st_d = ST_RESPOND;
      ST_RESPOND: st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      reg_q  <= '0;
      old_q  <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && op_valid) begin
        addr_q <= op_addr;
        reg_q  <= op_wdata;
      end
      if (st_q == ST_READ) old_q <= mem_rdata;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign own_req   = (st_q == ST_REQ_OWN);
  assign own_addr  = addr_q;
  assign mem_rd    = (st_q == ST_READ);
  assign mem_wr    = (st_q == ST_WRITE);
  assign mem_addr  = addr_q;
  assign mem_wdata = reg_q;
  assign done      = (st_q == ST_RESPOND);
  assign old_value = old_q;
  assign got_lock  = done && word_is_free(old_q);
  assign hold      = (st_q == ST_REQ_OWN) || (st_q == ST_READ) || (st_q == ST_WRITE);
  assign respond   = done;
  assign cur_addr  = addr_q;

  p_read_after_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> $past(own_grant));
  p_write_follows_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> mem_wr);
  p_done_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (done && !mem_wr));
  p_phases_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr, done, own_req}));
  p_idle_after_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/snoop_hold.sv
module snoop_hold #(
  parameter int AW         = 16,
  parameter int LINE_OFS_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          respond,
  input  logic [AW-1:0] cur_addr,
  input  logic          snp_in_valid,
  input  logic [AW-1:0] snp_in_addr,
  output logic          snp_in_ready,
  output logic          snp_out_valid,
  output logic [AW-1:0] snp_out_addr
);
  localparam int LW = AW - LINE_OFS_W;

  logic          buf_v;
  logic [AW-1:0] buf_a;
  logic          same_line, park, take, release_buf;

  function automatic logic [LW-1:0] line_of(input logic [AW-1:0] a);
    return a[AW-1:LINE_OFS_W];
  endfunction

  assign same_line   = (line_of(snp_in_addr) == line_of(cur_addr));
  assign park        = hold && snp_in_valid && same_line;
  assign take        = park && !buf_v;
  assign release_buf = respond && buf_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_v <= 1'b0;
      buf_a <= '0;
    end else if (take) begin
      buf_v <= 1'b1;
      buf_a <= snp_in_addr;
    end else if (release_buf) begin
      buf_v <= 1'b0;
    end
  end

  assign snp_out_valid = release_buf || (snp_in_valid && !park);
  assign snp_out_addr  = release_buf ? buf_a : snp_in_addr;
  assign snp_in_ready  = !release_buf && !(park && buf_v);

  p_no_leak_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && snp_in_valid && same_line) |-> !(snp_out_valid && snp_out_addr == snp_in_addr && !respond));
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_v && respond) |-> (snp_out_valid && snp_out_addr == buf_a));
  p_full_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_v && hold && snp_in_valid && same_line) |-> !snp_in_ready);
  p_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_v && hold) |=> buf_v && $stable(buf_a));
endmodule

// File: rtl/atomic_swap_unit.sv
module atomic_swap_unit #(
  parameter int AW         = 16,
  parameter int DW         = 32,
  parameter int LINE_OFS_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_wdata,
  output logic          busy,
  output logic          own_req,
  output logic [AW-1:0] own_addr,
  input  logic          own_grant,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic [DW-1:0] old_value,
  output logic          got_lock,
  input  logic          snp_in_valid,
  input  logic [AW-1:0] snp_in_addr,
  output logic          snp_in_ready,
  output logic          snp_out_valid,
  output logic [AW-1:0] snp_out_addr
);
  logic          hold, respond;
  logic [AW-1:0] cur_addr;

  xchg_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .op_valid(op_valid), .op_addr(op_addr), .op_wdata(op_wdata),
    .busy(busy), .own_req(own_req), .own_addr(own_addr), .own_grant(own_grant),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .old_value(old_value), .got_lock(got_lock),
    .hold(hold), .respond(respond), .cur_addr(cur_addr)
  );

  snoop_hold #(.AW(AW), .LINE_OFS_W(LINE_OFS_W)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .hold(hold), .respond(respond), .cur_addr(cur_addr),
    .snp_in_valid(snp_in_valid), .snp_in_addr(snp_in_addr),
    .snp_in_ready(snp_in_ready),
    .snp_out_valid(snp_out_valid), .snp_out_addr(snp_out_addr)
  );

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_rd || mem_wr || done || own_req));
endmodule

// File: tb/sim_atomic_swap_unit.sv
module sim_atomic_swap_unit;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          op_valid = 1'b0, own_grant = 1'b0, snp_in_valid = 1'b0;
  logic [AW-1:0] op_addr = '0, snp_in_addr = '0;
  logic [DW-1:0] op_wdata = '0;
  logic          busy, own_req, mem_rd, mem_wr, done, got_lock;
  logic          snp_in_ready, snp_out_valid;
  logic [AW-1:0] own_addr, mem_addr, snp_out_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, old_value;

  logic [DW-1:0] mem [16];
  assign mem_rdata = mem[mem_addr[5:2]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[5:2]] <= mem_wdata;

  int checks = 0;
  int fails  = 0;

  atomic_swap_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_addr(op_addr),
    .op_wdata(op_wdata), .busy(busy), .own_req(own_req), .own_addr(own_addr),
    .own_grant(own_grant), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .old_value(old_value), .got_lock(got_lock),
    .snp_in_valid(snp_in_valid), .snp_in_addr(snp_in_addr),
    .snp_in_ready(snp_in_ready), .snp_out_valid(snp_out_valid),
    .snp_out_addr(snp_out_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset busy", 32'(busy), 0);
    chk("R1 reset strobes", 32'({own_req, mem_rd, mem_wr, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", 32'({busy, own_req, mem_rd, mem_wr, done}), 0);
  endtask

  task automatic t_idle_pass;
    snp_in_valid = 1'b1; snp_in_addr = 16'h0150;
    #1;
    chk("R10 idle forward valid", 32'(snp_out_valid), 1);
    chk("R10 idle forward addr", 32'(snp_out_addr), 32'h0150);
    chk("R10 idle ready", 32'(snp_in_ready), 1);
    @(negedge clk);
    snp_in_valid = 1'b0;
  endtask

  // One exchange; with_snp injects requests while the grant is held back.
  task automatic t_swap(input logic [AW-1:0] a, input logic [DW-1:0] v,
                        input int delay, input bit with_snp);
    logic [DW-1:0] prev;
    logic [AW-1:0] other;
    prev  = mem[a[5:2]];
    other = a + 16'h0100;
    op_valid = 1'b1; op_addr = a; op_wdata = v;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R1 busy after start", 32'(busy), 1);
    chk("R2 own_req", 32'(own_req), 1);
    chk("R2 own_addr", 32'(own_addr), 32'(a));
    for (int i = 0; i < delay; i++) begin
      if (with_snp && i == 0) begin
        snp_in_valid = 1'b1; snp_in_addr = a;
        #1;
        chk("R6 same line not forwarded", 32'(snp_out_valid), 0);
        chk("R6 same line accepted", 32'(snp_in_ready), 1);
      end else if (with_snp && i == 1) begin
        snp_in_valid = 1'b1; snp_in_addr = a + 16'h0004;
        #1;
        chk("R8 buffer full ready", 32'(snp_in_ready), 0);
        chk("R8 buffer full not forwarded", 32'(snp_out_valid), 0);
      end else if (with_snp && i == 2) begin
        snp_in_valid = 1'b1; snp_in_addr = other;
        #1;
        chk("R9 other line valid", 32'(snp_out_valid), 1);
        chk("R9 other line addr", 32'(snp_out_addr), 32'(other));
      end else begin
        snp_in_valid = 1'b0;
      end
      chk("R2 no access before grant", 32'({mem_rd, mem_wr}), 0);
      @(negedge clk);
    end
    snp_in_valid = 1'b0;
    own_grant = 1'b1;
    @(negedge clk);
    chk("R2 read after grant", 32'({mem_rd, mem_wr}), 32'b10);
    chk("R2 read addr", 32'(mem_addr), 32'(a));
    @(negedge clk);
    chk("R3 write cycle", 32'({mem_rd, mem_wr}), 32'b01);
    chk("R3 write data", mem_wdata, v);
    chk("R3 write addr", 32'(mem_addr), 32'(a));
    @(negedge clk);
    own_grant = 1'b0;
    chk("R4 done pulse", 32'(done), 1);
    chk("R4 old value", old_value, prev);
    chk("R5 got_lock", 32'(got_lock), 32'(prev == '0));
    chk("R3 memory updated", mem[a[5:2]], v);
    if (with_snp) begin
      #1;
      chk("R7 held request released", 32'(snp_out_valid), 1);
      chk("R7 released addr", 32'(snp_out_addr), 32'(a));
    end
    @(negedge clk);
    chk("R4 done one cycle", 32'({done, busy}), 0);
    chk("R7 single release", 32'(snp_out_valid), 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    mem[9] = 32'h1234_5678;
    t_reset();
    t_idle_pass();
    t_swap(16'h0010, 32'h1, 2, 1'b0);          // free lock: acquired
    t_swap(16'h0010, 32'h1, 0, 1'b0);          // taken lock: retry
    t_swap(16'h0024, 32'hDEAD_BEEF, 0, 1'b0);  // arbitrary word
    t_swap(16'h0030, 32'h1, 4, 1'b1);          // snoops during the window
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule